// File: doc/BRIEF.md
# CCD Readout Region Classifier

This block sits on the digitized sample stream of one CCD readout channel and tracks where each sample lies on the sensor. From a frame-start pulse, a line-start pulse and a pixel-valid strobe it keeps a column and a row position. It labels every accepted sample with a region code: dummy, shielded row, shielded edge column, trusted dark reference, buffer, active or overclock. The label, the column and the row of each sample appear one clock after the sample.

Alongside the labels it builds a per-line dark level. Only the inner columns of the shielded column band contribute, and only in rows that are neither dummy nor shielded rows, because the outer shielded columns and the shielded rows can pick up stray light. When the last trusted dark sample of a line arrives, the block emits the scaled sum as an approximate mean, together with a one-cycle valid pulse. Every region width is a parameter, so the same block serves the full sensor geometry and reduced test geometries.

Top module: `ccd_region_tagger`

## Requirements
- R1: After reset, tag_valid_o and dark_avg_valid_o are 0, and tag_o, col_o, row_o and dark_avg_o are all zero.
- R2: Each accepted sample (pix_valid_i high with no start pulse in the same cycle) is reported one cycle later with tag_valid_o high and its column and row. The first sample after a start pulse has column 0, and the column rises by one per accepted sample. Cycles without pix_valid_i do not advance the column and report tag_valid_o low.
- R3: frame_start_i sets row and column to 0. line_start_i sets the column to 0 and advances the row by one. frame_start_i wins when both are high. A pix_valid_i in a cycle that carries a start pulse is dropped and reports nothing.
- R4: Tag 0 (dummy) is given to columns below DUMMY_COLS, to the first DUMMY_ROWS rows and to the DUMMY_ROWS rows after the bottom shielded band. A dummy column takes precedence over every other rule.
- R5: Columns of the shielded band, which starts at DUMMY_COLS and is DARK_COLS wide, get tag 2 (shielded edge) on the first and last column of the band and tag 3 (trusted dark) on the columns between them. This holds in every row that is not dummy, overclock or shielded.
- R6: The BUF_COLS columns after the shielded band and the BUF_ROWS rows on either side of the active rows get tag 4 (buffer). The remaining ACT_COLS by ACT_ROWS window gets tag 5 (active). A shielded column keeps tag 2 or 3 inside a buffer row.
- R7: The DARK_ROWS rows after the top dummy rows and the DARK_ROWS rows after the bottom buffer rows get tag 1 (shielded row) in every non-dummy column up to the last defined column.
- R8: A column at or past the last defined column gets tag 6 (overclock). This rule ranks below dummy columns and above all row rules. A row past the bottom dummy rows also gets tag 6 in non-dummy columns.
- R9: Column and row counters stop at their all-ones value instead of wrapping.
- R10: Once a line has delivered DARK_COLS-2 trusted dark samples, dark_avg_o becomes (sum * DIV_MUL) >> DIV_SHIFT. dark_avg_valid_o is high for exactly the cycle in which the last of those samples is reported. dark_avg_o keeps its value until the next result.
- R11: A scaled result above the all-ones value of DATA_W bits is clamped to all ones.
- R12: Samples tagged other than 3 never enter the sum. Either start pulse discards a partial sum. A line without a complete set of trusted samples, such as a shielded row, produces no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Start of frame pulse; also starts the first line |
| line_start_i | input | 1 | Start of line pulse |
| pix_valid_i | input | 1 | Sample strobe |
| pix_data_i | input | DATA_W | Digitized sample |
| tag_valid_o | output | 1 | A tagged sample is presented |
| tag_o | output | 3 | Region code (0 dummy, 1 shielded row, 2 shielded edge, 3 trusted dark, 4 buffer, 5 active, 6 overclock) |
| col_o | output | COL_W | Column of the tagged sample |
| row_o | output | ROW_W | Row of the tagged sample |
| dark_avg_o | output | DATA_W | Latest per-line dark level |
| dark_avg_valid_o | output | 1 | One-cycle pulse when dark_avg_o is refreshed |

## Verification
The hardest conditions to reach are the ones that depend on position deep inside a frame. Examples are a trusted dark column inside a buffer row, a row past the bottom dummy band, and counters driven to their ceiling. A line that is cut off after a partial dark sum and then followed by a full one is also hard to produce. The bench builds the DUT with a reduced geometry of a few columns and rows per region and narrow counters. It reaches each position with a frame pulse, a counted number of line pulses and a counted number of samples, so corner regions and counter saturation take only tens of cycles. The dark-sum cases use chosen sample values: bright values on the edge columns and a stale partial sum would each change the expected average.

// File: rtl/ccd_region_pkg.sv
package ccd_region_pkg;

    typedef enum logic [2:0] {
        RGN_DUMMY       = 3'd0,
        RGN_SHIELD_ROW  = 3'd1,
        RGN_SHIELD_EDGE = 3'd2,
        RGN_DARK_REF    = 3'd3,
        RGN_BUFFER      = 3'd4,
        RGN_ACTIVE      = 3'd5,
        RGN_OVERCLK     = 3'd6
    } region_e;

endpackage

// File: rtl/ccd_pos_counter.sv
module ccd_pos_counter #(
    parameter int COL_W = 13,
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             line_start_i,
    input  logic             pix_valid_i,
    output logic             take_o,
    output logic [COL_W-1:0] col_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pos_t;

    pos_t pos_d, pos_q;
    logic take;

    assign take = pix_valid_i && !frame_start_i && !line_start_i;

    always_comb begin
        pos_d = pos_q;
        if (frame_start_i) begin
            pos_d.col = '0;
            pos_d.row = '0;
        end else if (line_start_i) begin
            pos_d.col = '0;
            if (pos_q.row != '1) begin
                pos_d.row = pos_q.row + ROW_W'(1);
            end
        end else if (take) begin
            if (pos_q.col != '1) begin
                pos_d.col = pos_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign take_o = take;
    assign col_o  = pos_q.col;
    assign row_o  = pos_q.row;

    AST_COL_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pos_q.col == '1) |=> pos_q.col == '1); // R9
    AST_ROW_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_i && !frame_start_i && pos_q.row == '1) |=> pos_q.row == '1); // R9
    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (pos_q.col == '0 && pos_q.row == '0)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid_i && !frame_start_i && !line_start_i) |=> $stable(pos_q)); // R2

endmodule

// File: rtl/ccd_region_decode.sv
module ccd_region_decode
    import ccd_region_pkg::*;
#(
    parameter int COL_W      = 13,
    parameter int ROW_W      = 13,
    parameter int DUMMY_COLS = 11,
    parameter int DARK_COLS  = 22,
    parameter int BUF_COLS   = 12,
    parameter int ACT_COLS   = 3288,
    parameter int DUMMY_ROWS = 1,
    parameter int DARK_ROWS  = 22,
    parameter int BUF_ROWS   = 12,
    parameter int ACT_ROWS   = 4384
) (
    input  logic [COL_W-1:0] col_i,
    input  logic [ROW_W-1:0] row_i,
    output region_e          region_o
);

    localparam int C_DARK0 = DUMMY_COLS;
    localparam int C_DARKL = C_DARK0 + DARK_COLS - 1;
    localparam int C_BUF0  = C_DARK0 + DARK_COLS;
    localparam int C_ACT0  = C_BUF0 + BUF_COLS;
    localparam int C_END   = C_ACT0 + ACT_COLS;

    localparam int R_DARK0 = DUMMY_ROWS;
    localparam int R_BUF0  = R_DARK0 + DARK_ROWS;
    localparam int R_ACT0  = R_BUF0 + BUF_ROWS;
    localparam int R_BUF1  = R_ACT0 + ACT_ROWS;
    localparam int R_DARK1 = R_BUF1 + BUF_ROWS;
    localparam int R_DUM1  = R_DARK1 + DARK_ROWS;
    localparam int R_END   = R_DUM1 + DUMMY_ROWS;

    logic [31:0] c;
    logic [31:0] r;
    logic row_dummy, row_shield, row_buffer, col_shield, col_buffer;

    always_comb begin
        c = 32'(col_i);
        r = 32'(row_i);
        row_dummy  = (r < R_DARK0) || (r >= R_DUM1 && r < R_END);
        row_shield = (r >= R_DARK0 && r < R_BUF0) || (r >= R_DARK1 && r < R_DUM1);
        row_buffer = (r >= R_BUF0 && r < R_ACT0) || (r >= R_BUF1 && r < R_DARK1);
        col_shield = (c >= C_DARK0 && c < C_BUF0);
        col_buffer = (c >= C_BUF0 && c < C_ACT0);

        if (c < C_DARK0) begin
            region_o = RGN_DUMMY;
        end else if (c >= C_END) begin
            region_o = RGN_OVERCLK;
        end else if (row_dummy) begin
            region_o = RGN_DUMMY;
        end else if (r >= R_END) begin
            region_o = RGN_OVERCLK;
        end else if (row_shield) begin
            region_o = RGN_SHIELD_ROW;
        end else if (col_shield) begin
            region_o = (c == C_DARK0 || c == C_DARKL) ? RGN_SHIELD_EDGE : RGN_DARK_REF;
        end else if (col_buffer || row_buffer) begin
            region_o = RGN_BUFFER;
        end else begin
            region_o = RGN_ACTIVE;
        end
    end

endmodule

// File: rtl/ccd_dark_avg.sv
module ccd_dark_avg #(
    parameter int DATA_W    = 14,
    parameter int REF_CNT   = 20,
    parameter int DIV_MUL   = 13,
    parameter int DIV_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] avg_o,
    output logic              avg_valid_o
);

    localparam int CNT_W  = $clog2(REF_CNT + 1);
    localparam int SUM_W  = DATA_W + $clog2(REF_CNT + 1);
    localparam int MUL_W  = $clog2(DIV_MUL + 1);
    localparam int PROD_W = SUM_W + MUL_W;
    localparam logic [PROD_W-1:0] AVG_MAX = {{(PROD_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] avg;
        logic              vld;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [SUM_W-1:0]  sum_nx;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    always_comb begin
        acc_d     = acc_q;
        acc_d.vld = 1'b0;
        sum_nx    = acc_q.sum + SUM_W'(data_i);
        prod      = PROD_W'(sum_nx) * PROD_W'(DIV_MUL);
        scaled    = prod >> DIV_SHIFT;
        if (clear_i) begin
            acc_d.sum = '0;
            acc_d.cnt = '0;
        end else if (sample_i && acc_q.cnt < CNT_W'(REF_CNT)) begin
            acc_d.cnt = acc_q.cnt + CNT_W'(1);
            if (acc_q.cnt == CNT_W'(REF_CNT - 1)) begin
                acc_d.sum = '0;
                acc_d.vld = 1'b1;
                acc_d.avg = (scaled > AVG_MAX) ? {DATA_W{1'b1}} : scaled[DATA_W-1:0];
            end else begin
                acc_d.sum = sum_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign avg_o       = acc_q.avg;
    assign avg_valid_o = acc_q.vld;

    AST_AVG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.vld |=> !acc_q.vld); // R10
    AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q.vld |-> $stable(acc_q.avg)); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.cnt <= CNT_W'(REF_CNT)); // R12
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_q.cnt == '0 && acc_q.sum == '0 && !acc_q.vld)); // R12

endmodule

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
    import ccd_region_pkg::*;
#(
    parameter int DATA_W     = 14,
    parameter int COL_W      = 13,
    parameter int ROW_W      = 13,
    parameter int DUMMY_COLS = 11,
    parameter int DARK_COLS  = 22,
    parameter int BUF_COLS   = 12,
    parameter int ACT_COLS   = 3288,
    parameter int DUMMY_ROWS = 1,
    parameter int DARK_ROWS  = 22,
    parameter int BUF_ROWS   = 12,
    parameter int ACT_ROWS   = 4384,
    parameter int DIV_MUL    = 13,
    parameter int DIV_SHIFT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              line_start_i,
    input  logic              pix_valid_i,
    input  logic [DATA_W-1:0] pix_data_i,
    output logic              tag_valid_o,
    output logic [2:0]        tag_o,
    output logic [COL_W-1:0]  col_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [DATA_W-1:0] dark_avg_o,
    output logic              dark_avg_valid_o
);

    localparam int REF_CNT = DARK_COLS - 2;

    typedef struct packed {
        logic             vld;
        region_e          tag;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } out_t;

    logic             take;
    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;
    region_e          cur_rgn;
    out_t             out_d, out_q;

    ccd_pos_counter #(
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) pos_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .line_start_i  (line_start_i),
        .pix_valid_i   (pix_valid_i),
        .take_o        (take),
        .col_o         (cur_col),
        .row_o         (cur_row)
    );

    ccd_region_decode #(
        .COL_W      (COL_W),
        .ROW_W      (ROW_W),
        .DUMMY_COLS (DUMMY_COLS),
        .DARK_COLS  (DARK_COLS),
        .BUF_COLS   (BUF_COLS),
        .ACT_COLS   (ACT_COLS),
        .DUMMY_ROWS (DUMMY_ROWS),
        .DARK_ROWS  (DARK_ROWS),
        .BUF_ROWS   (BUF_ROWS),
        .ACT_ROWS   (ACT_ROWS)
    ) dec_i (
        .col_i    (cur_col),
        .row_i    (cur_row),
        .region_o (cur_rgn)
    );

    ccd_dark_avg #(
        .DATA_W    (DATA_W),
        .REF_CNT   (REF_CNT),
        .DIV_MUL   (DIV_MUL),
        .DIV_SHIFT (DIV_SHIFT)
    ) dark_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (frame_start_i || line_start_i),
        .sample_i    (take && cur_rgn == RGN_DARK_REF),
        .data_i      (pix_data_i),
        .avg_o       (dark_avg_o),
        .avg_valid_o (dark_avg_valid_o)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = take;
        if (take) begin
            out_d.tag = cur_rgn;
            out_d.col = cur_col;
            out_d.row = cur_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{vld: 1'b0, tag: RGN_DUMMY, col: '0, row: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign tag_valid_o = out_q.vld;
    assign tag_o       = out_q.tag;
    assign col_o       = out_q.col;
    assign row_o       = out_q.row;

    AST_TAG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && !frame_start_i && !line_start_i) |=> tag_valid_o); // R2
    AST_PULSE_DROPS_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i || line_start_i) |=> !tag_valid_o); // R3
    AST_AVG_ON_REF_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        dark_avg_valid_o |-> (tag_valid_o && tag_o == RGN_DARK_REF)); // R12
    AST_TAG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid_o |-> tag_o != 3'd7); // R8

endmodule

// File: tb/ccd_region_tagger_tb.sv
module ccd_region_tagger_tb_top;

    localparam int DW = 8;
    localparam int CW = 5;
    localparam int RW = 4;
    localparam int NV = 28;

    // {row, col, expected tag}
    localparam logic [11:0] VEC [NV] = '{
        {4'd0,  5'd0,  3'd0}, {4'd0,  5'd5,  3'd0}, {4'd0,  5'd20, 3'd6},
        {4'd1,  5'd1,  3'd0}, {4'd1,  5'd3,  3'd1}, {4'd2,  5'd14, 3'd1},
        {4'd3,  5'd2,  3'd2}, {4'd3,  5'd3,  3'd3}, {4'd3,  5'd5,  3'd3},
        {4'd3,  5'd6,  3'd2}, {4'd3,  5'd7,  3'd4}, {4'd3,  5'd10, 3'd4},
        {4'd4,  5'd0,  3'd0}, {4'd4,  5'd2,  3'd2}, {4'd4,  5'd4,  3'd3},
        {4'd4,  5'd8,  3'd4}, {4'd4,  5'd9,  3'd5}, {4'd4,  5'd14, 3'd5},
        {4'd4,  5'd15, 3'd6}, {4'd6,  5'd12, 3'd5}, {4'd7,  5'd9,  3'd4},
        {4'd7,  5'd4,  3'd3}, {4'd8,  5'd4,  3'd1}, {4'd9,  5'd12, 3'd1},
        {4'd10, 5'd9,  3'd0}, {4'd10, 5'd3,  3'd0}, {4'd11, 5'd9,  3'd6},
        {4'd13, 5'd4,  3'd6}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start_i = 1'b0;
    logic          line_start_i = 1'b0;
    logic          pix_valid_i = 1'b0;
    logic [DW-1:0] pix_data_i = '0;
    logic          tag_valid_o;
    logic [2:0]    tag_o;
    logic [CW-1:0] col_o;
    logic [RW-1:0] row_o;
    logic [DW-1:0] dark_avg_o;
    logic          dark_avg_valid_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ccd_region_tagger #(
        .DATA_W (DW), .COL_W (CW), .ROW_W (RW),
        .DUMMY_COLS (2), .DARK_COLS (5), .BUF_COLS (2), .ACT_COLS (6),
        .DUMMY_ROWS (1), .DARK_ROWS (2), .BUF_ROWS (1), .ACT_ROWS (3),
        .DIV_MUL (86), .DIV_SHIFT (8)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .frame_start_i (frame_start_i), .line_start_i (line_start_i),
        .pix_valid_i (pix_valid_i), .pix_data_i (pix_data_i),
        .tag_valid_o (tag_valid_o), .tag_o (tag_o),
        .col_o (col_o), .row_o (row_o),
        .dark_avg_o (dark_avg_o), .dark_avg_valid_o (dark_avg_valid_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_avg(input int s);
        int v;
        v = (s * 86) >> 8;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic pix(input logic [DW-1:0] d);
        pix_valid_i = 1'b1;
        pix_data_i  = d;
        @(negedge clk);
        pix_valid_i = 1'b0;
    endtask

    task automatic lstart();
        line_start_i = 1'b1;
        @(negedge clk);
        line_start_i = 1'b0;
    endtask

    task automatic fstart();
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
    endtask

    task automatic goto_pix(input int r, input int c);
        fstart();
        for (int k = 0; k < r; k++) lstart();
        for (int k = 0; k < c; k++) pix(8'd0);
        pix(8'd0);
    endtask

    // one line where shielded columns 2..6 carry e2, r3, r4, r5, e6
    task automatic dark_line(input int e2, input int r3, input int r4, input int r5,
                             input int e6, input string req, input int exp_v);
        for (int c = 0; c < 15; c++) begin
            case (c)
                2: pix(DW'(e2));
                3: pix(DW'(r3));
                4: pix(DW'(r4));
                5: pix(DW'(r5));
                6: pix(DW'(e6));
                default: pix(8'd7);
            endcase
            if (c == 5) begin
                chk(req, dark_avg_valid_o, 1);
                chk(req, dark_avg_o, exp_v);
            end else begin
                chk("R10", dark_avg_valid_o, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hit;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", tag_valid_o, 0);
        chk("R1", tag_o, 0);
        chk("R1", col_o, 0);
        chk("R1", row_o, 0);
        chk("R1", dark_avg_o, 0);
        chk("R1", dark_avg_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: tag, row and column of chosen positions
        for (int i = 0; i < NV; i++) begin
            int r, c, e;
            r = int'(VEC[i][11:8]);
            c = int'(VEC[i][7:3]);
            e = int'(VEC[i][2:0]);
            goto_pix(r, c);
            chk("R2", tag_valid_o, 1);
            chk("R2", col_o, c);
            chk("R3", row_o, r);
            case (e)
                0: chk("R4", tag_o, e);
                1: chk("R7", tag_o, e);
                2, 3: chk("R5", tag_o, e);
                4, 5: chk("R6", tag_o, e);
                default: chk("R8", tag_o, e);
            endcase
        end

        // R2: idle cycles neither advance nor report
        fstart();
        pix(8'd0);
        chk("R2", col_o, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R2", tag_valid_o, 0);
        end
        pix(8'd0);
        chk("R2", col_o, 1);

        // R3: sample coinciding with a line pulse is dropped
        fstart();
        lstart();
        pix_valid_i  = 1'b1;
        line_start_i = 1'b1;
        @(negedge clk);
        pix_valid_i  = 1'b0;
        line_start_i = 1'b0;
        chk("R3", tag_valid_o, 0);
        pix(8'd0);
        chk("R3", row_o, 2);
        chk("R3", col_o, 0);

        // R3: frame pulse wins over line pulse
        lstart();
        frame_start_i = 1'b1;
        line_start_i  = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
        line_start_i  = 1'b0;
        pix(8'd0);
        chk("R3", row_o, 0);
        chk("R3", col_o, 0);

        // R9: column counter stops at all ones
        fstart();
        for (int k = 0; k < 40; k++) pix(8'd0);
        chk("R9", col_o, 31);
        chk("R8", tag_o, 6);
        // R9: row counter stops at all ones
        for (int k = 0; k < 20; k++) lstart();
        pix(8'd0);
        chk("R9", row_o, 15);
        chk("R4", tag_o, 0);

        // R10: trusted samples 100+50+30, bright edges ignored
        fstart();
        repeat (4) lstart();
        dark_line(255, 100, 50, 30, 255, "R10", exp_avg(180));
        chk("R10", dark_avg_o, exp_avg(180));

        // R11: clamp at all ones
        lstart();
        dark_line(0, 255, 255, 255, 0, "R11", 255);

        // R12: partial sum discarded by a line pulse
        lstart();
        for (int c = 0; c < 4; c++) pix((c == 3) ? 8'd200 : 8'd7);
        lstart();
        dark_line(0, 10, 20, 30, 0, "R12", exp_avg(60));

        // R12: shielded row produces no pulse and leaves the level untouched
        fstart();
        lstart();
        hit = 0;
        for (int c = 0; c < 15; c++) begin
            pix(8'd200);
            if (dark_avg_valid_o) hit++;
        end
        chk("R12", hit, 0);
        chk("R12", dark_avg_o, exp_avg(60));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule